// File: doc/BRIEF.md
# Significance-Pattern Line Compressor and Expander

This block shrinks a 64-byte cache line by looking at each 32-bit word on its own and replacing it with a short code when its value is narrow or regular. A word may be a small value sign-extended from 4, 8 or 16 bits, a halfword followed by sixteen zero bits, two halfwords that are each a sign-extended byte, or one byte repeated four times. Each word becomes a 3-bit prefix followed by a payload whose size the prefix decides. Consecutive all-zero words fold into one run entry. No dictionary and no history are kept, so the words of a line never affect each other's codes.

The compressor takes one word per valid cycle, from a start-marked first word through the sixteenth. It builds the packed bit stream as it goes. One cycle after the last word it pulses a done flag with the stream's length in bits and its size in 8-byte segments. When the stream would need more than eight segments, the size saturates at eight and a flag marks the line to be stored uncompressed. A separate expander takes a packed stream and returns the sixteen words through a five-register pipeline that can start a new line every cycle.

Top module: `fpw_codec`

## Requirements
- R1: After synchronous reset, `c_done` and `d_valid` are 0, and `c_len_bits` and `c_segs` are 0.
- R2: Each non-zero word is coded as a 3-bit prefix followed by a payload. The prefixes and payloads are: 001 with bits [3:0] when the word is a sign extension of its low 4 bits; 010 with bits [7:0] for a sign extension of its low byte; 011 with bits [15:0] for a sign extension of its low halfword; 100 with bits [31:16] when bits [15:0] are zero; 101 with the 16-bit payload {bits[23:16], bits[7:0]} when each halfword is a sign extension of its own low byte; 110 with bits [7:0] when all four bytes are equal; and 111 with the whole 32-bit word.
- R3: When a word fits several patterns, the shortest code is used. Equal lengths are broken in the order SE4, SE8, repeated byte, SE16, zero-padded halfword, byte-pair.
- R4: A run of consecutive zero words is coded as prefix 000 with a 3-bit field holding the run length minus one, up to eight words per entry. A ninth zero starts a new entry. A pending run is emitted when a non-zero word or the end of the line closes it.
- R5: Entries are packed least significant bit first from stream bit 0 with no gaps. Within an entry the prefix occupies the lowest three bits and the payload follows, and stream bits above the length are 0.
- R6: `c_segs` is the bit length rounded up to 64-bit units. When the length exceeds 512, `c_segs` is 8 and `c_raw` is 1; otherwise `c_raw` is 0.
- R7: A word is taken on each cycle with `c_valid` high. `c_start` together with `c_valid` marks word 0. Cycles with `c_valid` low are skipped, and `c_valid` with no line open and no `c_start` is ignored. `c_done` is high for exactly the one cycle after the sixteenth word is taken, and the results hold until the next start.
- R8: The expander presents a line on `d_words` with `d_valid` high exactly five clock edges after `d_start` is sampled, and accepts a new stream on every cycle.
- R9: Expanding the compressor's stream returns the original sixteen words, with word i on `d_words[32*i+31:32*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_start | input | 1 | Marks the word on `c_word` as word 0 of a new line (with `c_valid`) |
| c_valid | input | 1 | `c_word` carries a word this cycle |
| c_word | input | 32 | Word to compress |
| c_done | output | 1 | One-cycle pulse after the last word; results valid |
| c_stream | output | 560 | Packed code stream, LSB first |
| c_len_bits | output | 10 | Stream length in bits |
| c_segs | output | 4 | Size in 64-bit segments, saturated at 8 |
| c_raw | output | 1 | Line needs more than 8 segments and is kept uncompressed |
| d_start | input | 1 | `d_stream` holds a stream to expand |
| d_stream | input | 560 | Packed code stream to expand |
| d_valid | output | 1 | `d_words` holds an expanded line |
| d_words | output | 512 | Sixteen expanded words, word 0 in the low bits |

## Verification
In the compressor, a single cycle can both close a pending zero run and emit the entry of the next word. On the line's last word it can instead add a final run entry, sometimes right after emitting a full run of eight. The bench provokes these cases with lines that put zero runs before non-zero words, that run nine zeros in a row, and that end in zeros. A behavioural queue model of the bit stream judges them, comparing length, segment count and every stream bit when done rises. Round trips through the expander, including two streams fed on consecutive cycles, confirm that a run crossing a pipeline stage boundary comes back intact.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam int WORD_W      = 32;
    localparam int PFX_W       = 3;
    localparam int RUN_W       = 3;
    localparam int MAX_ENTRY_W = PFX_W + WORD_W;

    typedef enum logic [PFX_W-1:0] {
        PFX_ZRUN  = 3'd0,
        PFX_SE4   = 3'd1,
        PFX_SE8   = 3'd2,
        PFX_SE16  = 3'd3,
        PFX_HPAD  = 3'd4,
        PFX_HBYTE = 3'd5,
        PFX_REP   = 3'd6,
        PFX_RAW   = 3'd7
    } pfx_e;

    typedef struct packed {
        pfx_e              pfx;
        logic [WORD_W-1:0] payload;
    } code_t;

    // Payload width selected by a prefix.
    function automatic logic [5:0] fpw_pay_width(pfx_e p);
        case (p)
            PFX_ZRUN:                     return 6'(RUN_W);
            PFX_SE4:                      return 6'd4;
            PFX_SE8, PFX_REP:             return 6'd8;
            PFX_SE16, PFX_HPAD, PFX_HBYTE: return 6'd16;
            default:                      return 6'd32;
        endcase
    endfunction

    function automatic logic [5:0] fpw_entry_len(pfx_e p);
        return 6'(PFX_W) + fpw_pay_width(p);
    endfunction

    // Picks the shortest matching pattern; order decides ties.
    function automatic code_t fpw_classify(logic [WORD_W-1:0] w);
        code_t c;
        c.payload = '0;
        if (w[31:3] == {29{w[3]}}) begin
            c.pfx = PFX_SE4;
            c.payload[3:0] = w[3:0];
        end else if (w[31:7] == {25{w[7]}}) begin
            c.pfx = PFX_SE8;
            c.payload[7:0] = w[7:0];
        end else if (w[31:8] == {3{w[7:0]}}) begin
            c.pfx = PFX_REP;
            c.payload[7:0] = w[7:0];
        end else if (w[31:15] == {17{w[15]}}) begin
            c.pfx = PFX_SE16;
            c.payload[15:0] = w[15:0];
        end else if (w[15:0] == 16'h0000) begin
            c.pfx = PFX_HPAD;
            c.payload[15:0] = w[31:16];
        end else if ((w[31:23] == {9{w[23]}}) && (w[15:7] == {9{w[7]}})) begin
            c.pfx = PFX_HBYTE;
            c.payload[15:0] = {w[23:16], w[7:0]};
        end else begin
            c.pfx = PFX_RAW;
            c.payload = w;
        end
        return c;
    endfunction

    function automatic logic [MAX_ENTRY_W-1:0] fpw_entry(code_t c);
        return {c.payload, c.pfx};
    endfunction

    function automatic logic [MAX_ENTRY_W-1:0] fpw_run_entry(logic [RUN_W-1:0] len_m1);
        return MAX_ENTRY_W'({len_m1, PFX_ZRUN});
    endfunction

    // Rebuilds a word from a prefix and the bits that follow it.
    function automatic logic [WORD_W-1:0] fpw_expand(pfx_e p, logic [WORD_W-1:0] pl);
        case (p)
            PFX_ZRUN:  return '0;
            PFX_SE4:   return {{28{pl[3]}}, pl[3:0]};
            PFX_SE8:   return {{24{pl[7]}}, pl[7:0]};
            PFX_SE16:  return {{16{pl[15]}}, pl[15:0]};
            PFX_HPAD:  return {pl[15:0], 16'h0000};
            PFX_HBYTE: return {{8{pl[15]}}, pl[15:8], {8{pl[7]}}, pl[7:0]};
            PFX_REP:   return {4{pl[7:0]}};
            default:   return pl;
        endcase
    endfunction

endpackage

// File: rtl/fpw_compressor.sv
module fpw_compressor
    import fpw_pkg::*;
#(
    parameter int WORDS    = 16,
    parameter int SEG_BITS = 64,
    parameter int MAX_SEGS = 8,
    parameter int RUN_MAX  = 8,
    localparam int STREAM_W = WORDS * MAX_ENTRY_W,
    localparam int LEN_W    = $clog2(STREAM_W + 1),
    localparam int SEG_W    = $clog2(MAX_SEGS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                valid,
    input  logic [WORD_W-1:0]   word,
    output logic                done,
    output logic [STREAM_W-1:0] stream,
    output logic [LEN_W-1:0]    len_bits,
    output logic [SEG_W-1:0]    segs,
    output logic                raw
);
    localparam int IDX_W     = $clog2(WORDS);
    localparam int RUNC_W    = $clog2(RUN_MAX + 1);
    localparam int RAW_LIMIT = SEG_BITS * MAX_SEGS;

    logic                busy_q, done_q, raw_q;
    logic [IDX_W-1:0]    idx_q;
    logic [RUNC_W-1:0]   run_q;
    logic [STREAM_W-1:0] stream_q;
    logic [LEN_W-1:0]    len_q;
    logic [SEG_W-1:0]    segs_q;

    logic                first, take, last;
    logic [STREAM_W-1:0] acc;
    logic [LEN_W-1:0]    alen;
    logic [RUNC_W-1:0]   run;
    logic [SEG_W-1:0]    segs_n;
    logic                raw_n;
    code_t               cd;

    assign first = valid && start;
    assign take  = valid && (start || busy_q);

    always_comb begin
        acc  = first ? '0 : stream_q;
        alen = first ? '0 : len_q;
        run  = first ? '0 : run_q;
        last = first ? (WORDS == 1) : (idx_q == IDX_W'(WORDS - 1));
        cd   = fpw_classify(word);
        // Close a pending run before a non-zero word or when it is full.
        if ((run != '0) && ((word != '0) || (run == RUNC_W'(RUN_MAX)))) begin
            acc  = acc | (STREAM_W'(fpw_run_entry(RUN_W'(run - RUNC_W'(1)))) << alen);
            alen = alen + LEN_W'(PFX_W + RUN_W);
            run  = '0;
        end
        if (word == '0) begin
            run = run + RUNC_W'(1);
        end else begin
            acc  = acc | (STREAM_W'(fpw_entry(cd)) << alen);
            alen = alen + LEN_W'(fpw_entry_len(cd.pfx));
        end
        // The line's end closes whatever run is still open.
        if (last && (run != '0)) begin
            acc  = acc | (STREAM_W'(fpw_run_entry(RUN_W'(run - RUNC_W'(1)))) << alen);
            alen = alen + LEN_W'(PFX_W + RUN_W);
            run  = '0;
        end
        if (int'(alen) > RAW_LIMIT) begin
            segs_n = SEG_W'(MAX_SEGS);
            raw_n  = 1'b1;
        end else begin
            segs_n = SEG_W'((int'(alen) + SEG_BITS - 1) / SEG_BITS);
            raw_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            raw_q    <= 1'b0;
            idx_q    <= '0;
            run_q    <= '0;
            stream_q <= '0;
            len_q    <= '0;
            segs_q   <= '0;
        end else if (take) begin
            stream_q <= acc;
            len_q    <= alen;
            run_q    <= run;
            idx_q    <= first ? IDX_W'(1) : idx_q + IDX_W'(1);
            busy_q   <= !last;
            done_q   <= last;
            if (last) begin
                segs_q <= segs_n;
                raw_q  <= raw_n;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done     = done_q;
    assign stream   = stream_q;
    assign len_bits = len_q;
    assign segs     = segs_q;
    assign raw      = raw_q;

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R4: an open run never holds more words than one entry can carry
    a_r4_run_cap: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUNC_W'(RUN_MAX));
    // R5: appending within a line never shrinks the stream
    a_r5_len_grows: assert property (@(posedge clk) disable iff (rst)
        (take && !first) |=> (len_q >= $past(len_q)));
    // R6: reported size stays within the segment budget; raw implies full size
    a_r6_seg_cap: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((segs_q <= SEG_W'(MAX_SEGS)) && (!raw_q || (segs_q == SEG_W'(MAX_SEGS)))));

endmodule

// File: rtl/fpw_dec_stage.sv
module fpw_dec_stage
    import fpw_pkg::*;
#(
    parameter int WORDS    = 16,
    parameter int FIRST    = 0,
    parameter int COUNT    = 4,
    parameter int RUN_MAX  = 8,
    localparam int STREAM_W = WORDS * MAX_ENTRY_W,
    localparam int LEN_W    = $clog2(STREAM_W + 1),
    localparam int RUNC_W   = $clog2(RUN_MAX + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [STREAM_W-1:0]           in_stream,
    input  logic [LEN_W-1:0]              in_cur,
    input  logic [RUNC_W-1:0]             in_run,
    input  logic [WORDS-1:0][WORD_W-1:0]  in_words,
    output logic                          out_valid,
    output logic [STREAM_W-1:0]           out_stream,
    output logic [LEN_W-1:0]              out_cur,
    output logic [RUNC_W-1:0]             out_run,
    output logic [WORDS-1:0][WORD_W-1:0]  out_words
);
    logic                         valid_q;
    logic [STREAM_W-1:0]          stream_q;
    logic [LEN_W-1:0]             cur_q;
    logic [RUNC_W-1:0]            run_q;
    logic [WORDS-1:0][WORD_W-1:0] words_q;

    logic [LEN_W-1:0]             cur_n;
    logic [RUNC_W-1:0]            run_n;
    logic [WORDS-1:0][WORD_W-1:0] words_n;

    always_comb begin
        logic [MAX_ENTRY_W-1:0] win;
        pfx_e                   p;
        cur_n   = in_cur;
        run_n   = in_run;
        words_n = in_words;
        for (int k = 0; k < COUNT; k++) begin
            win = MAX_ENTRY_W'(in_stream >> cur_n);
            p   = pfx_e'(win[PFX_W-1:0]);
            if (run_n != '0) begin
                words_n[FIRST+k] = '0;
                run_n = run_n - RUNC_W'(1);
            end else if (p == PFX_ZRUN) begin
                words_n[FIRST+k] = '0;
                run_n = RUNC_W'(win[PFX_W+RUN_W-1:PFX_W]);
                cur_n = cur_n + LEN_W'(PFX_W + RUN_W);
            end else begin
                words_n[FIRST+k] = fpw_expand(p, win[MAX_ENTRY_W-1:PFX_W]);
                cur_n = cur_n + LEN_W'(fpw_entry_len(p));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            stream_q <= '0;
            cur_q    <= '0;
            run_q    <= '0;
            words_q  <= '0;
        end else begin
            valid_q  <= in_valid;
            stream_q <= in_stream;
            cur_q    <= cur_n;
            run_q    <= run_n;
            words_q  <= words_n;
        end
    end

    assign out_valid  = valid_q;
    assign out_stream = stream_q;
    assign out_cur    = cur_q;
    assign out_run    = run_q;
    assign out_words  = words_q;

    // R5: the read position only moves forward through a stream
    a_r5_cursor_forward: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (cur_q >= $past(in_cur)));
    // R4: a carried run never exceeds what one entry encodes
    a_r4_carry_cap: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUNC_W'(RUN_MAX - 1));

endmodule

// File: rtl/fpw_decompressor.sv
module fpw_decompressor
    import fpw_pkg::*;
#(
    parameter int WORDS      = 16,
    parameter int DEC_STAGES = 4,
    parameter int RUN_MAX    = 8,
    localparam int STREAM_W = WORDS * MAX_ENTRY_W,
    localparam int LEN_W    = $clog2(STREAM_W + 1),
    localparam int RUNC_W   = $clog2(RUN_MAX + 1),
    localparam int PER_STG  = WORDS / DEC_STAGES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [STREAM_W-1:0]           stream,
    output logic                          valid,
    output logic [WORDS-1:0][WORD_W-1:0]  words
);
    logic [DEC_STAGES:0]                          v;
    logic [DEC_STAGES:0][STREAM_W-1:0]            st;
    logic [DEC_STAGES:0][LEN_W-1:0]               cur;
    logic [DEC_STAGES:0][RUNC_W-1:0]              run;
    logic [DEC_STAGES:0][WORDS-1:0][WORD_W-1:0]   wd;

    // Capture register: the first of the pipeline's registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            v[0]  <= 1'b0;
            st[0] <= '0;
        end else begin
            v[0]  <= start;
            st[0] <= stream;
        end
    end
    assign cur[0] = '0;
    assign run[0] = '0;
    assign wd[0]  = '0;

    for (genvar s = 0; s < DEC_STAGES; s++) begin : g_stage
        fpw_dec_stage #(
            .WORDS   (WORDS),
            .FIRST   (s * PER_STG),
            .COUNT   (PER_STG),
            .RUN_MAX (RUN_MAX)
        ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (v[s]),
            .in_stream  (st[s]),
            .in_cur     (cur[s]),
            .in_run     (run[s]),
            .in_words   (wd[s]),
            .out_valid  (v[s+1]),
            .out_stream (st[s+1]),
            .out_cur    (cur[s+1]),
            .out_run    (run[s+1]),
            .out_words  (wd[s+1])
        );
    end

    assign valid = v[DEC_STAGES];
    assign words = wd[DEC_STAGES];

    // R9: a well-formed stream is fully consumed, no run left open, nothing beyond it
    a_r9_stream_consumed: assert property (@(posedge clk) disable iff (rst)
        v[DEC_STAGES] |-> ((run[DEC_STAGES] == '0) &&
                           ((st[DEC_STAGES] >> cur[DEC_STAGES]) == '0)));
    // R8: output validity follows the stage before it by exactly one edge
    a_r8_valid_step: assert property (@(posedge clk) disable iff (rst)
        $rose(v[DEC_STAGES]) |-> $past(v[DEC_STAGES-1]));

endmodule

// File: rtl/fpw_codec.sv
module fpw_codec
    import fpw_pkg::*;
#(
    parameter int WORDS      = 16,
    parameter int SEG_BITS   = 64,
    parameter int MAX_SEGS   = 8,
    parameter int RUN_MAX    = 8,
    parameter int DEC_STAGES = 4,
    localparam int STREAM_W = WORDS * MAX_ENTRY_W,
    localparam int LEN_W    = $clog2(STREAM_W + 1),
    localparam int SEG_W    = $clog2(MAX_SEGS + 1),
    localparam int LINE_W   = WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                c_start,
    input  logic                c_valid,
    input  logic [WORD_W-1:0]   c_word,
    output logic                c_done,
    output logic [STREAM_W-1:0] c_stream,
    output logic [LEN_W-1:0]    c_len_bits,
    output logic [SEG_W-1:0]    c_segs,
    output logic                c_raw,
    input  logic                d_start,
    input  logic [STREAM_W-1:0] d_stream,
    output logic                d_valid,
    output logic [LINE_W-1:0]   d_words
);
    logic [WORDS-1:0][WORD_W-1:0] dec_words;

    fpw_compressor #(
        .WORDS    (WORDS),
        .SEG_BITS (SEG_BITS),
        .MAX_SEGS (MAX_SEGS),
        .RUN_MAX  (RUN_MAX)
    ) u_comp (
        .clk      (clk),
        .rst      (rst),
        .start    (c_start),
        .valid    (c_valid),
        .word     (c_word),
        .done     (c_done),
        .stream   (c_stream),
        .len_bits (c_len_bits),
        .segs     (c_segs),
        .raw      (c_raw)
    );

    fpw_decompressor #(
        .WORDS      (WORDS),
        .DEC_STAGES (DEC_STAGES),
        .RUN_MAX    (RUN_MAX)
    ) u_decomp (
        .clk    (clk),
        .rst    (rst),
        .start  (d_start),
        .stream (d_stream),
        .valid  (d_valid),
        .words  (dec_words)
    );

    assign d_words = dec_words;

endmodule

// File: tb/fpw_codec_tb.sv
module fpw_codec_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         c_start = 1'b0;
    logic         c_valid = 1'b0;
    logic [31:0]  c_word = '0;
    logic         c_done;
    logic [559:0] c_stream;
    logic [9:0]   c_len_bits;
    logic [3:0]   c_segs;
    logic         c_raw;
    logic         d_start = 1'b0;
    logic [559:0] d_stream = '0;
    logic         d_valid;
    logic [511:0] d_words;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0]  line [16];
    logic [559:0] exp_stream;
    int           exp_len;
    logic [31:0]  seed = 32'h1badb002;
    bit           mq[$];

    always #5 clk = ~clk;

    fpw_codec u_dut (
        .clk(clk), .rst(rst),
        .c_start(c_start), .c_valid(c_valid), .c_word(c_word),
        .c_done(c_done), .c_stream(c_stream), .c_len_bits(c_len_bits),
        .c_segs(c_segs), .c_raw(c_raw),
        .d_start(d_start), .d_stream(d_stream),
        .d_valid(d_valid), .d_words(d_words)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [559:0] act, input logic [559:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    task automatic mpush(input logic [31:0] v, input int n);
        for (int b = 0; b < n; b++) mq.push_back(v[b]);
    endtask

    function automatic bit in_rng(input int x, input int lo, input int hi);
        return (x >= lo) && (x <= hi);
    endfunction

    task automatic model_word(input logic [31:0] w);
        int sv;
        sv = $signed(w);
        if (in_rng(sv, -8, 7))            begin mpush(1, 3); mpush(w, 4); end
        else if (in_rng(sv, -128, 127))   begin mpush(2, 3); mpush(w, 8); end
        else if (w[31:24] == w[7:0] && w[23:16] == w[7:0] && w[15:8] == w[7:0])
                                          begin mpush(6, 3); mpush(w, 8); end
        else if (in_rng(sv, -32768, 32767)) begin mpush(3, 3); mpush(w, 16); end
        else if (w[15:0] == 0)            begin mpush(4, 3); mpush(w >> 16, 16); end
        else if (in_rng(int'($signed(w[31:16])), -128, 127) &&
                 in_rng(int'($signed(w[15:0])), -128, 127))
                                          begin mpush(5, 3); mpush({w[23:16], w[7:0]}, 16); end
        else                              begin mpush(7, 3); mpush(w, 32); end
    endtask

    task automatic model_line();
        int zrun;
        zrun = 0;
        mq.delete();
        for (int i = 0; i < 16; i++) begin
            if (line[i] == 0) begin
                if (zrun == 8) begin mpush(0, 3); mpush(7, 3); zrun = 0; end
                zrun++;
            end else begin
                if (zrun > 0) begin mpush(0, 3); mpush(zrun - 1, 3); zrun = 0; end
                model_word(line[i]);
            end
        end
        if (zrun > 0) begin mpush(0, 3); mpush(zrun - 1, 3); end
        exp_len = mq.size();
        exp_stream = '0;
        for (int b = 0; b < exp_len; b++) exp_stream[b] = mq[b];
    endtask

    function automatic logic [511:0] line_flat();
        logic [511:0] f;
        for (int i = 0; i < 16; i++) f[32*i +: 32] = line[i];
        return f;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] gen_word(input int kind, input logic [31:0] r);
        case (kind)
            1: return {{28{r[3]}}, r[3:0]};
            2: return {{24{r[7]}}, r[7:0]};
            3: return {4{r[15:8]}};
            4: return {{16{r[15]}}, r[15:0]};
            5: return {r[31:16], 16'h0};
            6: return {{8{r[23]}}, r[23:16], {8{r[7]}}, r[7:0]};
            7: return r;
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- stimulus tasks ----------------
    task automatic compress_line(input string tag, input bit gaps);
        model_line();
        for (int i = 0; i < 16; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                c_valid = 1'b0; c_start = 1'b0; c_word = 32'hdead_beef;
            end
            @(negedge clk);
            chk(c_done == 1'b0, "R7", {tag, " done low mid-line"}, 560'(c_done), 560'(0));
            c_valid = 1'b1; c_start = (i == 0); c_word = line[i];
        end
        @(negedge clk);
        c_valid = 1'b0; c_start = 1'b0; c_word = '0;
        chk(c_done == 1'b1, "R7", {tag, " done after last word"}, 560'(c_done), 560'(1));
        chk(int'(c_len_bits) == exp_len, "R4", {tag, " length"}, 560'(c_len_bits), 560'(exp_len));
        chk(c_stream == exp_stream, "R2", {tag, " stream bits"}, c_stream, exp_stream);
        chk(int'(c_segs) == ((exp_len > 512) ? 8 : (exp_len + 63) / 64), "R6",
            {tag, " segments"}, 560'(c_segs), 560'((exp_len > 512) ? 8 : (exp_len + 63) / 64));
        chk(c_raw == (exp_len > 512), "R6", {tag, " raw flag"}, 560'(c_raw), 560'(exp_len > 512));
        @(negedge clk);
        chk(c_done == 1'b0, "R7", {tag, " done one cycle"}, 560'(c_done), 560'(0));
        chk(c_stream == exp_stream, "R7", {tag, " result held"}, c_stream, exp_stream);
    endtask

    task automatic expand_check(input string tag, input logic [559:0] s);
        logic [511:0] want;
        want = line_flat();
        @(negedge clk);
        d_start = 1'b1; d_stream = s;
        @(negedge clk);
        d_start = 1'b0; d_stream = '0;
        repeat (3) @(negedge clk);
        chk(d_valid == 1'b0, "R8", {tag, " not valid after 4 edges"}, 560'(d_valid), 560'(0));
        @(negedge clk);
        chk(d_valid == 1'b1, "R8", {tag, " valid after 5 edges"}, 560'(d_valid), 560'(1));
        chk(d_words == want, "R9", {tag, " round trip"}, 560'(d_words), 560'(want));
    endtask

    task automatic run_line(input string tag, input bit gaps);
        compress_line(tag, gaps);
        expand_check(tag, c_stream);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [559:0] sa, sb;
        logic [511:0] la, lb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(c_done == 0 && d_valid == 0, "R1", "flags after reset", 560'({c_done, d_valid}), 560'(0));
        chk(c_len_bits == 0 && c_segs == 0, "R1", "length after reset", 560'({c_len_bits, c_segs}), 560'(0));

        // R7: valid with no open line and no start is ignored
        for (int i = 0; i < 4; i++) begin
            c_valid = 1'b1; c_start = 1'b0; c_word = 32'h1234_5678;
            @(negedge clk);
        end
        c_valid = 1'b0;
        @(negedge clk);
        chk(c_done == 0 && c_len_bits == 0, "R7", "stray valid ignored", 560'({c_done, c_len_bits}), 560'(0));

        // R4: all zeros -> two full runs of 8
        for (int i = 0; i < 16; i++) line[i] = 32'h0;
        run_line("zeros", 1'b0);
        chk(c_len_bits == 10'd12, "R4", "two run entries", 560'(c_len_bits), 560'(12));
        chk(c_stream[11:0] == 12'b111000_111000, "R5", "run entry layout", 560'(c_stream[11:0]), 560'(12'hE38));

        // R2/R3: every pattern and priority ties
        line = '{32'h5, 32'hFFFFFF80, 32'h1234, 32'hABCD0000, 32'hFF80007F, 32'h5A5A5A5A,
                 32'h12345678, 32'hFFFFFFFF, 32'h7F, 32'h80, 32'h7F7F7F7F, 32'hFFFF8000,
                 32'h8000, 32'h80808080, 32'h0, 32'h0};
        run_line("patterns", 1'b0);
        chk(c_stream[6:0] == {4'h5, 3'b001}, "R3", "SE4 first entry", 560'(c_stream[6:0]), 560'({4'h5, 3'b001}));

        // R4: nine zeros, word, run ending the line (flush + entry in one cycle)
        line = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h11223344, 0, 0, 0, 0, 0, 0};
        run_line("runs", 1'b1);

        // R6: all raw -> 560 bits, saturated
        for (int i = 0; i < 16; i++) line[i] = 32'h12345678 ^ (i << 20);
        run_line("allraw", 1'b0);
        chk(c_raw == 1 && c_segs == 4'd8, "R6", "saturation", 560'({c_raw, c_segs}), 560'({1'b1, 4'd8}));

        // R6: exactly 512 bits -> 8 segments, not raw
        for (int i = 0; i < 14; i++) line[i] = 32'h12345678 ^ (i << 20);
        line[14] = 32'h40; line[15] = 32'h41;
        run_line("exact512", 1'b0);
        chk(c_len_bits == 10'd512 && c_raw == 0, "R6", "512 boundary", 560'({c_len_bits, c_raw}), 560'({10'd512, 1'b0}));

        // R6: 520 bits -> raw
        line[15] = 32'h1234;
        run_line("over512", 1'b1);

        // Random mixes
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] r;
                r = rnd();
                line[i] = gen_word(int'(r[2:0]) + ((r[30] && r[29]) ? 0 : 0) , rnd());
            end
            run_line($sformatf("rand%0d", t), t[0]);
        end

        // R8: two streams on consecutive cycles
        line = '{32'h5, 32'hFFFFFF80, 0, 0, 0, 32'hABCD0000, 0, 0, 0, 0, 0, 32'h12345678,
                 32'h7F7F7F7F, 0, 32'hFF80007F, 32'h3};
        model_line(); sa = exp_stream; la = line_flat();
        line = '{0, 0, 0, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hCAFE0000, 0, 0};
        model_line(); sb = exp_stream; lb = line_flat();
        @(negedge clk); d_start = 1'b1; d_stream = sa;
        @(negedge clk); d_stream = sb;
        @(negedge clk); d_start = 1'b0; d_stream = '0;
        repeat (3) @(negedge clk);
        chk(d_valid == 1 && d_words == la, "R8", "first of pair", 560'(d_words), 560'(la));
        @(negedge clk);
        chk(d_valid == 1 && d_words == lb, "R8", "second of pair", 560'(d_words), 560'(lb));
        @(negedge clk);
        chk(d_valid == 0, "R8", "pipeline drained", 560'(d_valid), 560'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule